// File: doc/BRIEF.md
# Dual-Slot Card Access Bridge

This block connects a host with a narrow byte bus to two common-interface card slots. The host reaches a small register file in two steps. An access with the index flag raised names a register. The next access without the flag reads or writes that register. Internal registers hold the card address, the target slot and the target space. A read or write of the card data register runs one strobed cycle on the card bus. The host ready output stays low until that cycle ends.

The same register file also controls the slots. For each slot it provides a reset with completion status and a transport-stream enable. It also drives two active-low tuner reset lines, provides card status interrupts, and holds a fixed revision byte. Card presence and readiness pass through a synchronizer before any logic uses them. A slot reset drives the card reset line for a set number of cycles. It then waits for the card to report ready, and only then does its bit clear.

Top module: `cam_bridge`

## Requirements
- R1: An accepted access (hb_sel high while hb_ready is high) with hb_idx high stores hb_wdata as the register index. An accepted access with hb_idx low reads (hb_wr low) or writes (hb_wr high) the indexed register. Every access while hb_ready is low is ignored.
- R2: Index 0x04 holds card address bits 6..0 in its bits 7..1 and reads bit 0 as 0. Index 0x05 holds address bits 13..7 in its bits 6..0 and reads bit 7 as 0. card_addr always shows the assembled 14-bit address.
- R3: At index 0x07, bit 7 picks the slot and bit 6 picks the space (1 = control/IO, shown on card_space). Bit 3 drives ts_en[0] and bit 2 drives ts_en[1]. Bits 1..0 read as 0. During a card cycle only the chip select of the chosen slot is low.
- R4: A data-phase access to index 0x06 starts a card cycle. The selected card_ce_n bit goes low for STROBE_CYC+1 cycles. card_oe_n (read) or card_we_n (write) goes low for the last STROBE_CYC of them. hb_ready is low for the whole cycle.
- R5: A card write drives the host byte on card_dout. A card read captures card_din at the last strobe edge and shows it on hb_rdata in the same cycle that hb_ready returns high. Other register reads update hb_rdata one cycle after the access.
- R6: Writing 1 to index 0x07 bit 5 (slot 0) or bit 4 (slot 1) raises card_rst for that slot for RST_CYC cycles. The block then waits for the synchronized card ready. That bit reads 1 until the card reports ready and 0 afterwards.
- R7: A reset request for a slot whose reset is still in progress has no effect, and a 0 written to a reset bit has no effect.
- R8: Index 0x01 is a plain byte that resets to 0x18. tuner_rst_n[0] follows its bit 4 and tuner_rst_n[1] follows its bit 3.
- R9: A change in a slot's synchronized presence sets that slot's pending flag. irq is high while pending[0] is set with index 0x00 bit 2 set, or while pending[1] is set with bit 6 set. Reading 0x00 returns {2'b00, pend1, pend0, ready1, present1, ready0, present0} and clears the pending flags that were returned.
- R10: card_present and card_ready each pass through two flops before they reach the status bits, so a presence change shows on irq three clock edges after it is driven.
- R11: Index 0x0F reads REVISION and ignores writes. Reads of unmapped indices return 0.
- R12: After reset, hb_ready is 1, card_rst and irq are 0, tuner_rst_n is 2'b11, and all chip selects and strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hb_sel | input | 1 | Host access request, one cycle per access |
| hb_idx | input | 1 | Access is an index phase |
| hb_wr | input | 1 | Access writes (1) or reads (0) |
| hb_wdata | input | 8 | Host write byte or register index |
| hb_rdata | output | 8 | Host read byte |
| hb_ready | output | 1 | Low while a card cycle runs |
| card_addr | output | 14 | Card address |
| card_space | output | 1 | 1 = control/IO space, 0 = attribute memory |
| card_ce_n | output | 2 | Active-low chip select per slot |
| card_oe_n | output | 1 | Active-low read strobe |
| card_we_n | output | 1 | Active-low write strobe |
| card_dout | output | 8 | Byte written to the card |
| card_din | input | 8 | Byte read from the card |
| card_present | input | 2 | Card presence per slot, asynchronous |
| card_ready | input | 2 | Card ready per slot, asynchronous |
| card_rst | output | 2 | Active-high card reset per slot |
| ts_en | output | 2 | Transport-stream enable per slot |
| tuner_rst_n | output | 2 | Active-low tuner resets |
| irq | output | 1 | Card status interrupt |

## Verification
The hardest case is a slot reset that has finished its hold time but is still waiting for card ready. The bench holds the slot's ready input low and polls the bus-control register well past RST_CYC. In that state it writes the reset bit again to confirm that the write is ignored, and only then raises ready. It also sends host accesses while a card cycle is running, to show that they leave the index and the registers unchanged. A per-clock behavioural model shadows the synchronizer delay and catches any off-by-one in the interrupt and reset timing.

// File: rtl/cam_pkg.sv
package cam_pkg;
   typedef enum logic [1:0] {CYC_IDLE, CYC_SETUP, CYC_STROBE} cyc_state_t;
   typedef enum logic [1:0] {SR_IDLE, SR_HOLD, SR_WAIT} srst_state_t;

   localparam logic [7:0] IDX_IRQ  = 8'h00;
   localparam logic [7:0] IDX_TUN  = 8'h01;
   localparam logic [7:0] IDX_ALO  = 8'h04;
   localparam logic [7:0] IDX_AHI  = 8'h05;
   localparam logic [7:0] IDX_DATA = 8'h06;
   localparam logic [7:0] IDX_CTL  = 8'h07;
   localparam logic [7:0] IDX_REV  = 8'h0F;

   localparam logic [7:0] TUN_RESET_VAL = 8'h18;
endpackage

// File: rtl/cam_sync.sv
module cam_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cam_sync needs at least two stages");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[STAGES-2:0], d[b]};
      end
      assign q[b] = chain[STAGES-1];
   end
endmodule

// File: rtl/cam_card_cycle.sv
module cam_card_cycle
   import cam_pkg::*;
#(
   parameter int STROBE_CYC = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic start_rd,
   output logic busy,
   output logic ce,
   output logic rd_strobe,
   output logic wr_strobe,
   output logic finish_rd
);
   localparam int CW = (STROBE_CYC < 2) ? 1 : $clog2(STROBE_CYC);
   localparam logic [CW-1:0] LAST = CW'(STROBE_CYC - 1);

   cyc_state_t st;
   logic [CW-1:0] cnt;
   logic is_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= CYC_IDLE;
         cnt   <= '0;
         is_rd <= 1'b0;
      end else begin
         unique case (st)
            CYC_IDLE: if (start) begin
               st    <= CYC_SETUP;
               is_rd <= start_rd;
            end
            CYC_SETUP: begin
               st  <= CYC_STROBE;
               cnt <= '0;
            end
            CYC_STROBE: begin
               if (cnt == LAST) st <= CYC_IDLE;
               else             cnt <= cnt + 1'b1;
            end
            default: st <= CYC_IDLE;
         endcase
      end
   end

   assign busy      = (st != CYC_IDLE);
   assign ce        = busy;
   assign rd_strobe = (st == CYC_STROBE) && is_rd;
   assign wr_strobe = (st == CYC_STROBE) && !is_rd;
   assign finish_rd = (st == CYC_STROBE) && (cnt == LAST) && is_rd;
endmodule

// File: rtl/cam_slot_reset.sv
module cam_slot_reset
   import cam_pkg::*;
#(
   parameter int RST_CYC = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic ready,
   output logic card_rst,
   output logic busy
);
   localparam int CW = (RST_CYC < 2) ? 1 : $clog2(RST_CYC);
   localparam logic [CW-1:0] LAST = CW'(RST_CYC - 1);

   srst_state_t st;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= SR_IDLE;
         cnt <= '0;
      end else begin
         unique case (st)
            SR_IDLE: if (start) begin
               st  <= SR_HOLD;
               cnt <= '0;
            end
            SR_HOLD: begin
               if (cnt == LAST) st <= SR_WAIT;
               else             cnt <= cnt + 1'b1;
            end
            SR_WAIT: if (ready) st <= SR_IDLE;
            default: st <= SR_IDLE;
         endcase
      end
   end

   assign card_rst = (st == SR_HOLD);
   assign busy     = (st != SR_IDLE);
endmodule

// File: rtl/cam_bridge.sv
module cam_bridge
   import cam_pkg::*;
#(
   parameter int          ADDR_W      = 14,
   parameter int          STROBE_CYC  = 3,
   parameter int          RST_CYC     = 16,
   parameter int          SYNC_STAGES = 2,
   parameter logic [7:0]  REVISION    = 8'h2A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hb_sel,
   input  logic              hb_idx,
   input  logic              hb_wr,
   input  logic [7:0]        hb_wdata,
   output logic [7:0]        hb_rdata,
   output logic              hb_ready,
   output logic [ADDR_W-1:0] card_addr,
   output logic              card_space,
   output logic [1:0]        card_ce_n,
   output logic              card_oe_n,
   output logic              card_we_n,
   output logic [7:0]        card_dout,
   input  logic [7:0]        card_din,
   input  logic [1:0]        card_present,
   input  logic [1:0]        card_ready,
   output logic [1:0]        card_rst,
   output logic [1:0]        ts_en,
   output logic [1:0]        tuner_rst_n,
   output logic              irq
);
   localparam int NSLOT  = 2;
   localparam int LO_W   = 7;
   localparam int HI_W   = ADDR_W - LO_W;

   if (ADDR_W != 14) begin : g_bad_aw
      $error("cam_bridge address layout needs ADDR_W == 14");
   end
   if (STROBE_CYC < 1) begin : g_bad_strobe
      $error("STROBE_CYC must be at least 1");
   end
   if (RST_CYC < 1) begin : g_bad_rst
      $error("RST_CYC must be at least 1");
   end

   // synchronized status: [3:2] ready, [1:0] present
   logic [2*NSLOT-1:0] stat_s;
   logic [NSLOT-1:0]   pres_s, rdy_s, pres_q, pend;

   cam_sync #(.WIDTH(2*NSLOT), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({card_ready, card_present}), .q(stat_s)
   );
   assign pres_s = stat_s[NSLOT-1:0];
   assign rdy_s  = stat_s[2*NSLOT-1:NSLOT];

   // register file
   logic [7:0]        reg_idx, irq_ctl, tun_ctl;
   logic [LO_W-1:0]   addr_lo;
   logic [HI_W-1:0]   addr_hi;
   logic              slot_sel, space_sel;
   logic [NSLOT-1:0]  ts_q;

   logic accept, acc_idx, acc_wr, acc_rd;
   logic cyc_busy, cyc_ce, cyc_rd, cyc_wr, cyc_fin;
   logic [NSLOT-1:0] rst_busy, rst_req;

   assign hb_ready = !cyc_busy;
   assign accept   = hb_sel && hb_ready;
   assign acc_idx  = accept && hb_idx;
   assign acc_wr   = accept && !hb_idx && hb_wr;
   assign acc_rd   = accept && !hb_idx && !hb_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_idx   <= '0;
         irq_ctl   <= '0;
         tun_ctl   <= TUN_RESET_VAL;
         addr_lo   <= '0;
         addr_hi   <= '0;
         slot_sel  <= 1'b0;
         space_sel <= 1'b0;
         ts_q      <= '0;
         card_dout <= '0;
      end else begin
         if (acc_idx) reg_idx <= hb_wdata;
         if (acc_wr) begin
            unique case (reg_idx)
               IDX_IRQ:  irq_ctl <= hb_wdata;
               IDX_TUN:  tun_ctl <= hb_wdata;
               IDX_ALO:  addr_lo <= hb_wdata[7:1];
               IDX_AHI:  addr_hi <= hb_wdata[HI_W-1:0];
               IDX_DATA: card_dout <= hb_wdata;
               IDX_CTL: begin
                  slot_sel  <= hb_wdata[7];
                  space_sel <= hb_wdata[6];
                  ts_q      <= {hb_wdata[2], hb_wdata[3]};
               end
               default: ;
            endcase
         end
      end
   end

   // card cycle engine
   logic cyc_start;
   assign cyc_start = (acc_wr || acc_rd) && (reg_idx == IDX_DATA);

   cam_card_cycle #(.STROBE_CYC(STROBE_CYC)) u_cycle (
      .clk(clk), .rst_n(rst_n),
      .start(cyc_start), .start_rd(acc_rd),
      .busy(cyc_busy), .ce(cyc_ce),
      .rd_strobe(cyc_rd), .wr_strobe(cyc_wr),
      .finish_rd(cyc_fin)
   );

   assign card_addr  = {addr_hi, addr_lo};
   assign card_space = space_sel;
   assign card_oe_n  = !cyc_rd;
   assign card_we_n  = !cyc_wr;
   always_comb begin
      card_ce_n = '1;
      if (cyc_ce) card_ce_n[slot_sel] = 1'b0;
   end

   // slot resets: bit 5 drives slot 0, bit 4 drives slot 1
   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      assign rst_req[s] = acc_wr && (reg_idx == IDX_CTL) && hb_wdata[5-s];
      cam_slot_reset #(.RST_CYC(RST_CYC)) u_srst (
         .clk(clk), .rst_n(rst_n),
         .start(rst_req[s]), .ready(rdy_s[s]),
         .card_rst(card_rst[s]), .busy(rst_busy[s])
      );
   end

   assign ts_en       = ts_q;
   assign tuner_rst_n = {tun_ctl[3], tun_ctl[4]};

   // interrupt pending
   logic [NSLOT-1:0] pend_clr, irq_en;
   assign pend_clr = (acc_rd && reg_idx == IDX_IRQ) ? pend : '0;
   assign irq_en   = {irq_ctl[6], irq_ctl[2]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pres_q <= '0;
         pend   <= '0;
      end else begin
         pres_q <= pres_s;
         pend   <= (pend & ~pend_clr) | (pres_s ^ pres_q);
      end
   end
   assign irq = |(pend & irq_en);

   // read path
   logic [7:0] rd_mux;
   always_comb begin
      unique case (reg_idx)
         IDX_IRQ: rd_mux = {2'b00, pend[1], pend[0], rdy_s[1], pres_s[1],
                            rdy_s[0], pres_s[0]};
         IDX_TUN: rd_mux = tun_ctl;
         IDX_ALO: rd_mux = {addr_lo, 1'b0};
         IDX_AHI: rd_mux = {{(8-HI_W){1'b0}}, addr_hi};
         IDX_CTL: rd_mux = {slot_sel, space_sel, rst_busy[0], rst_busy[1],
                            ts_q[0], ts_q[1], 2'b00};
         IDX_REV: rd_mux = REVISION;
         default: rd_mux = 8'h00;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              hb_rdata <= '0;
      else if (cyc_fin)                        hb_rdata <= card_din;
      else if (acc_rd && reg_idx != IDX_DATA)  hb_rdata <= rd_mux;
   end
endmodule

// File: rtl/cam_bridge_chk.sv
module cam_bridge_chk #(
   parameter int ADDR_W = 14
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hb_ready,
   input logic [1:0]        card_ce_n,
   input logic              card_oe_n,
   input logic              card_we_n,
   input logic [7:0]        card_dout,
   input logic [ADDR_W-1:0] card_addr,
   input logic [1:0]        card_rst,
   input logic [1:0]        rst_busy
);
   assert_ce_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~card_ce_n));

   assert_strobe_inside_ce_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!card_oe_n || !card_we_n) |-> (card_ce_n != 2'b11));

   assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(!card_oe_n && !card_we_n));

   assert_host_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (card_ce_n != 2'b11) |-> !hb_ready);

   assert_write_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!card_we_n && $past(!card_we_n)) |-> ($stable(card_dout) && $stable(card_addr)));

   assert_rst_reports_busy0_R6: assert property (@(posedge clk) disable iff (!rst_n)
      card_rst[0] |-> rst_busy[0]);

   assert_rst_reports_busy1_R6: assert property (@(posedge clk) disable iff (!rst_n)
      card_rst[1] |-> rst_busy[1]);
endmodule

bind cam_bridge cam_bridge_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .hb_ready(hb_ready),
   .card_ce_n(card_ce_n), .card_oe_n(card_oe_n), .card_we_n(card_we_n),
   .card_dout(card_dout), .card_addr(card_addr),
   .card_rst(card_rst), .rst_busy(rst_busy)
);

// File: tb/cam_bridge_bench.sv
module cam_bridge_bench;
   localparam int S   = 3;
   localparam int RC  = 16;
   localparam logic [7:0] REV = 8'h2A;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hb_sel = 0, hb_idx = 0, hb_wr = 0;
   logic [7:0] hb_wdata = 0, card_din = 0;
   logic [1:0] card_present = 0, card_ready = 0;
   logic [7:0] hb_rdata, card_dout;
   logic hb_ready, card_space, card_oe_n, card_we_n, irq;
   logic [13:0] card_addr;
   logic [1:0] card_ce_n, card_rst, ts_en, tuner_rst_n;

   always #10 clk = ~clk;

   cam_bridge #(.STROBE_CYC(S), .RST_CYC(RC), .REVISION(REV)) u_cam_bridge (
      .clk(clk), .rst_n(rst_n), .hb_sel(hb_sel), .hb_idx(hb_idx), .hb_wr(hb_wr),
      .hb_wdata(hb_wdata), .hb_rdata(hb_rdata), .hb_ready(hb_ready),
      .card_addr(card_addr), .card_space(card_space), .card_ce_n(card_ce_n),
      .card_oe_n(card_oe_n), .card_we_n(card_we_n), .card_dout(card_dout),
      .card_din(card_din), .card_present(card_present), .card_ready(card_ready),
      .card_rst(card_rst), .ts_en(ts_en), .tuner_rst_n(tuner_rst_n), .irq(irq)
   );

   int n_chk = 0, n_fail = 0;

   task automatic chk(input string req, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int m_idx, m_busy, m_isrd, m_slot, m_space, m_addr, m_dout, m_rdata;
   int m_intc, m_tun, m_ts0, m_ts1;
   int m_hold[2], m_wait[2];
   logic [3:0] m_s1, m_s2;
   logic [1:0] m_psq, m_pend;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_idx = 0; m_busy = 0; m_isrd = 0; m_slot = 0; m_space = 0;
         m_addr = 0; m_dout = 0; m_rdata = 0; m_intc = 0; m_tun = 8'h18;
         m_ts0 = 0; m_ts1 = 0; m_s1 = 0; m_s2 = 0; m_psq = 0; m_pend = 0;
         for (int s = 0; s < 2; s++) begin m_hold[s] = 0; m_wait[s] = 0; end
      end else begin
         automatic logic acc = hb_sel && (m_busy == 0);
         automatic logic [1:0] o_ps = m_s2[1:0];
         automatic logic [1:0] o_rs = m_s2[3:2];
         automatic logic [1:0] o_pend = m_pend;
         automatic logic [1:0] o_rb, setp, clr;
         for (int s = 0; s < 2; s++) o_rb[s] = (m_hold[s] > 0) || (m_wait[s] != 0);
         setp = o_ps ^ m_psq;
         clr = 0;
         m_s2 = m_s1;
         m_s1 = {card_ready, card_present};
         m_psq = o_ps;
         if (m_busy > 0) begin
            if (m_busy == 1 && m_isrd != 0) m_rdata = card_din;
            m_busy--;
         end
         for (int s = 0; s < 2; s++) begin
            if (m_wait[s] != 0 && o_rs[s]) m_wait[s] = 0;
            else if (m_hold[s] > 0) begin
               m_hold[s]--;
               if (m_hold[s] == 0) m_wait[s] = 1;
            end
         end
         if (acc) begin
            if (hb_idx) m_idx = hb_wdata;
            else if (hb_wr) begin
               case (m_idx)
                  0: m_intc = hb_wdata;
                  1: m_tun = hb_wdata;
                  4: m_addr = (m_addr & 14'h3F80) | hb_wdata[7:1];
                  5: m_addr = (m_addr & 14'h007F) | (int'(hb_wdata[6:0]) << 7);
                  6: begin m_busy = S + 1; m_isrd = 0; m_dout = hb_wdata; end
                  7: begin
                     m_slot = hb_wdata[7]; m_space = hb_wdata[6];
                     m_ts0 = hb_wdata[3]; m_ts1 = hb_wdata[2];
                     if (hb_wdata[5] && !o_rb[0]) m_hold[0] = RC;
                     if (hb_wdata[4] && !o_rb[1]) m_hold[1] = RC;
                  end
                  default: ;
               endcase
            end else begin
               case (m_idx)
                  0: begin
                     m_rdata = {2'b00, o_pend, o_rs[1], o_ps[1], o_rs[0], o_ps[0]};
                     clr = o_pend;
                  end
                  1: m_rdata = m_tun;
                  4: m_rdata = (m_addr & 8'h7F) << 1;
                  5: m_rdata = m_addr >> 7;
                  6: begin m_busy = S + 1; m_isrd = 1; end
                  7: m_rdata = (m_slot << 7) | (m_space << 6) | (o_rb[0] << 5)
                               | (o_rb[1] << 4) | (m_ts0 << 3) | (m_ts1 << 2);
                  15: m_rdata = REV;
                  default: m_rdata = 0;
               endcase
            end
         end
         m_pend = (m_pend & ~clr) | setp;
      end
   end

   // per-clock comparison away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         automatic int e_ce = (m_busy > 0) ? (m_slot ? 2'b01 : 2'b10) : 2'b11;
         automatic int strb = (m_busy > 0) && (m_busy <= S);
         automatic int e_irq = (m_pend[0] && m_intc[2]) || (m_pend[1] && m_intc[6]);
         chk("R1 R4 hb_ready", hb_ready, m_busy == 0);
         chk("R3 R4 card_ce_n", card_ce_n, e_ce);
         chk("R4 card_oe_n", card_oe_n, !(strb && m_isrd != 0));
         chk("R4 card_we_n", card_we_n, !(strb && m_isrd == 0));
         chk("R2 card_addr", card_addr, m_addr);
         chk("R3 card_space", card_space, m_space);
         chk("R5 card_dout", card_dout, m_dout);
         chk("R1 R5 hb_rdata", hb_rdata, m_rdata);
         chk("R6 R7 card_rst", card_rst, {m_hold[1] > 0, m_hold[0] > 0});
         chk("R3 ts_en", ts_en, {m_ts1[0], m_ts0[0]});
         chk("R8 tuner_rst_n", tuner_rst_n, {m_tun[3], m_tun[4]});
         chk("R9 R10 irq", irq, e_irq);
      end
   end

   // ---------------- host tasks ----------------
   task automatic acc(input logic i, input logic w, input logic [7:0] d);
      hb_sel = 1; hb_idx = i; hb_wr = w; hb_wdata = d;
      @(negedge clk);
      hb_sel = 0; hb_idx = 0; hb_wr = 0;
   endtask

   task automatic wait_rdy();
      while (!hb_ready) @(negedge clk);
   endtask

   task automatic wr_reg(input logic [7:0] i, input logic [7:0] d);
      acc(1, 1, i); acc(0, 1, d); wait_rdy();
   endtask

   task automatic rd_reg(input logic [7:0] i, output logic [7:0] d);
      acc(1, 1, i); acc(0, 0, 8'h00); wait_rdy(); d = hb_rdata;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      // R12 reset state
      chk("R12 hb_ready", hb_ready, 1);
      chk("R12 card_rst", card_rst, 0);
      chk("R12 tuner_rst_n", tuner_rst_n, 2'b11);
      chk("R12 irq", irq, 0);
      chk("R12 card_ce_n", card_ce_n, 2'b11);
      rst_n = 1;
      @(negedge clk);

      // R11 revision and unmapped
      rd_reg(8'h0F, v); chk("R11 revision", v, REV);
      wr_reg(8'h0F, 8'h55);
      rd_reg(8'h0F, v); chk("R11 revision write ignored", v, REV);
      rd_reg(8'h02, v); chk("R11 unmapped", v, 0);

      // R2 address
      wr_reg(8'h04, 8'hFF);
      wr_reg(8'h05, 8'hFF);
      chk("R2 addr all ones", card_addr, 14'h3FFF);
      rd_reg(8'h04, v); chk("R2 low readback", v, 8'hFE);
      rd_reg(8'h05, v); chk("R2 high readback", v, 8'h7F);
      wr_reg(8'h04, 8'h5A);
      wr_reg(8'h05, 8'h23);
      chk("R2 addr pattern", card_addr, (14'h23 << 7) | 14'h2D);

      // R3 bus control
      wr_reg(8'h07, 8'hCB);
      rd_reg(8'h07, v); chk("R3 ctl readback", v, 8'hC8);
      chk("R3 ts_en", ts_en, 2'b01);

      // R4 R5 card write on slot 1, card read on slot 1
      wr_reg(8'h06, 8'h3C);
      chk("R5 card_dout", card_dout, 8'h3C);
      card_din = 8'hA5;
      rd_reg(8'h06, v); chk("R5 card read", v, 8'hA5);
      wr_reg(8'h07, 8'h04);
      card_din = 8'h96;
      rd_reg(8'h06, v); chk("R5 card read slot0", v, 8'h96);

      // R1 accesses during a busy card cycle are ignored
      acc(1, 1, 8'h06);
      acc(0, 0, 8'h00);
      acc(1, 1, 8'h01);
      acc(0, 1, 8'h00);
      wait_rdy();
      chk("R1 tuner untouched", tuner_rst_n, 2'b11);
      card_din = 8'h11;
      acc(0, 0, 8'h00); wait_rdy();
      chk("R1 index kept", hb_rdata, 8'h11);

      // R6 R7 slot reset with card not ready
      card_ready = 2'b00;
      wr_reg(8'h07, 8'h20);
      chk("R6 rst active", card_rst, 2'b01);
      rd_reg(8'h07, v); chk("R6 busy bit", v, 8'h20);
      repeat (RC + 6) @(negedge clk);
      chk("R6 rst released", card_rst, 2'b00);
      rd_reg(8'h07, v); chk("R6 waits for ready", v, 8'h20);
      wr_reg(8'h07, 8'h28);
      chk("R7 restart ignored", card_rst, 2'b00);
      wr_reg(8'h07, 8'h08);
      rd_reg(8'h07, v); chk("R7 zero no effect", v, 8'h28);
      card_ready = 2'b01;
      repeat (4) @(negedge clk);
      rd_reg(8'h07, v); chk("R6 done", v, 8'h08);
      card_ready = 2'b11;
      wr_reg(8'h07, 8'h10);
      chk("R6 slot1 rst", card_rst, 2'b10);
      repeat (RC + 4) @(negedge clk);
      rd_reg(8'h07, v); chk("R6 slot1 done", v, 8'h00);

      // R8 tuner pulse
      wr_reg(8'h01, 8'h08);
      chk("R8 tuner0 reset", tuner_rst_n, 2'b10);
      wr_reg(8'h01, 8'h10);
      chk("R8 tuner1 reset", tuner_rst_n, 2'b01);
      wr_reg(8'h01, 8'h18);
      rd_reg(8'h01, v); chk("R8 readback", v, 8'h18);

      // R9 R10 interrupts; ready has settled, clear old pend first
      rd_reg(8'h00, v);
      wr_reg(8'h00, 8'h44);
      card_present = 2'b01;
      repeat (4) @(negedge clk);
      chk("R9 irq slot0", irq, 1);
      rd_reg(8'h00, v); chk("R9 status", v, 8'h1B);
      chk("R9 cleared", irq, 0);
      card_present = 2'b11;
      repeat (2) @(negedge clk);
      chk("R10 not yet", irq, 0);
      @(negedge clk);
      chk("R10 third edge", irq, 1);
      wr_reg(8'h00, 8'h04);
      chk("R9 masked", irq, 0);
      rd_reg(8'h00, v); chk("R9 status slot1", v, 8'h2F);

      repeat (3) @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule